// File: doc/BRIEF.md
# Sequential Booth Multiplier with Selectable Radix

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full signed product of `2*WIDTH` bits. A caller presents the multiplicand, the multiplier and a scheme select, then pulses `start` while the block is idle. The block raises `busy` while it iterates. It then pulses `done` for one cycle, and the product stays on the output until the next accepted start.

Two recoding schemes share one accumulator and shift register.

- **Radix-2.** Each step looks at the lowest multiplier bit and the bit shifted out before it. Depending on that pair it subtracts the multiplicand, adds it, or leaves the accumulator alone, and then shifts by one place.
- **Radix-4.** Each step looks at an overlapping group of three bits. It picks one of 0, ±M or ±2M and shifts by two places, so a run takes about half as many steps.

The latency depends only on the scheme and the width, never on the operand values. Both schemes give identical products.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After that edge `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` pulse sampled high while `busy` is 0 is accepted, and `busy` reads 1 after that edge. A `start` sampled while `busy` is 1 is ignored, and so are the operand and `mode` values presented with it. The run in progress finishes with its own operands and latency.
- R3: `done` reads 1 exactly S clock edges after the accepting edge, and `busy` reads 0 from that same edge. S is `WIDTH` in radix-2 mode (`mode`=0) and ceil(`WIDTH`/2) in radix-4 mode (`mode`=1).
- R4: In radix-2 mode (`mode`=0), `product` equals the signed product of `mcand` and `mplier` as a `2*WIDTH`-bit two's-complement value. The step rules are: bit pair (Q0, Q-1) = (1,0) subtracts M; (0,1) adds M; (0,0) and (1,1) only shift.
- R5: In radix-4 mode (`mode`=1), `product` equals the same signed product. The step rules map each bit triple to a digit: 000 and 111 give 0; 001 and 010 give +M; 011 gives +2M; 100 gives −2M; 101 and 110 give −M.
- R6: For every pair of operand values, the two modes return identical products.
- R7: For odd `WIDTH`, the multiplier is sign-extended by one bit before radix-4 recoding. The most negative operands must multiply correctly (−16 × −16 = 256 at the default width).
- R8: `done` is high for exactly one cycle per accepted start. `product` holds its value from that cycle until the next accepted start.
- R9: The scheme and the multiplicand are captured at acceptance. Changes on `mode`, `mcand` or `mplier` during a run do not affect that run.
- R10: A multiplier with alternating bits, which forces an add or subtract on every radix-2 step, completes with the same latency as any other multiplier and gives the correct product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiplication; only accepted while idle |
| mode | input | 1 | 0 = radix-2 pair decoding, 1 = radix-4 triple recoding |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
Three situations are hard to reach from the ports:

- **Accumulator headroom.** The ±2M digits stress it only when large operands of both signs meet odd-width sign extension. The stimulus sweeps every operand pair at the default width in both schemes, which reaches every triple at every step position, including the most negative values.
- **Interference during a run.** The stimulus pulses `start` mid-run with different operands and the other scheme. The scoreboard then expects the original product at the original latency and flags any extra `done`.
- **Worst-case pattern.** An alternating-bit multiplier is applied to confirm that the data-dependent path does not alter timing.

// File: rtl/booth_pkg.sv
// Shared types for the sequential Booth multiplier.
package booth_pkg;

    // Recoding scheme selected at start.
    typedef enum logic {
        MODE_RADIX2 = 1'b0,
        MODE_RADIX4 = 1'b1
    } booth_mode_e;

    // Partial-product selection produced by a recoder.
    typedef struct packed {
        logic zero;   // add nothing
        logic neg;    // subtract instead of add
        logic dbl;    // use twice the multiplicand
    } pp_sel_t;

endpackage

// File: rtl/booth_pair_dec.sv
// Radix-2 recoder: maps the pair (Q0, Q-1) to add, subtract or nothing.
// Assumes pair_i[1] is the current multiplier LSB and pair_i[0] the bit
// shifted out on the previous step. Never requests a doubled multiplicand.
module booth_pair_dec
    import booth_pkg::*;
(
    input  logic [1:0] pair_i,
    output pp_sel_t    sel_o
);

    // Decode the bit pair into a partial-product choice.
    always_comb begin
        sel_o = '{zero: 1'b1, neg: 1'b0, dbl: 1'b0};
        unique case (pair_i)
            2'b10:   sel_o = '{zero: 1'b0, neg: 1'b1, dbl: 1'b0};
            2'b01:   sel_o = '{zero: 1'b0, neg: 1'b0, dbl: 1'b0};
            default: sel_o = '{zero: 1'b1, neg: 1'b0, dbl: 1'b0};
        endcase
    end

endmodule

// File: rtl/booth_triple_dec.sv
// Radix-4 recoder: maps an overlapping bit triple to a digit in {-2..+2}.
// Assumes trip_i = {Q1, Q0, Q-1} of the current shift position.
module booth_triple_dec
    import booth_pkg::*;
(
    input  logic [2:0] trip_i,
    output pp_sel_t    sel_o
);

    // Decode the triple into a signed digit selection.
    always_comb begin
        sel_o = '{zero: 1'b1, neg: 1'b0, dbl: 1'b0};
        unique case (trip_i)
            3'b001, 3'b010: sel_o = '{zero: 1'b0, neg: 1'b0, dbl: 1'b0};
            3'b011:         sel_o = '{zero: 1'b0, neg: 1'b0, dbl: 1'b1};
            3'b100:         sel_o = '{zero: 1'b0, neg: 1'b1, dbl: 1'b1};
            3'b101, 3'b110: sel_o = '{zero: 1'b0, neg: 1'b1, dbl: 1'b0};
            default:        sel_o = '{zero: 1'b1, neg: 1'b0, dbl: 1'b0};
        endcase
    end

endmodule

// File: rtl/booth_step_ctrl.sv
// Iteration controller: accepts a start while idle, counts the steps of
// the chosen scheme and pulses done after the last one.
// Assumes STEPS_R2 >= STEPS_R4 >= 1.
module booth_step_ctrl
    import booth_pkg::*;
#(
    parameter int STEPS_R2 = 5,
    parameter int STEPS_R4 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  booth_mode_e mode_i,
    output logic        load_o,
    output logic        step_o,
    output logic        busy_o,
    output logic        done_o
);

    localparam int CNTW = $clog2(STEPS_R2 + 1);

    logic            busy_q;
    logic            done_q;
    logic [CNTW-1:0] left_q;

    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // Step counter with busy and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            left_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                left_q <= (mode_i == MODE_RADIX4) ? CNTW'(STEPS_R4) : CNTW'(STEPS_R2);
            end else if (busy_q) begin
                left_q <= left_q - 1'b1;
                if (left_q == CNTW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    p_done_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));

    p_count_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (left_q != '0));

    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && left_q != CNTW'(1)) |=> (busy_q && left_q == CNTW'($past(left_q) - 1'b1)));

endmodule

// File: rtl/booth_seq_mul.sv
// Sequential signed multiplier with radix-2 and radix-4 Booth recoding.
// Accumulator is two bits wider than the multiplicand so that +/-2M cannot
// wrap; for odd WIDTH the multiplier register gets one sign-extension bit.
// Product bits are a fixed slice of the {acc, mplier} register per scheme.
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int QE       = WIDTH + (WIDTH % 2);
    localparam int AW       = WIDTH + 2;
    localparam int CW       = AW + QE;
    localparam int PW       = 2 * WIDTH;
    localparam int STEPS_R2 = WIDTH;
    localparam int STEPS_R4 = QE / 2;
    localparam int R2_OFF   = QE - WIDTH;

    logic [AW-1:0]     acc_q;
    logic [QE-1:0]     qr_q;
    logic              qm1_q;
    logic [WIDTH-1:0]  mcand_q;
    booth_mode_e       mode_q;
    logic [QE-1:0]     mplier_ext;
    logic              load_w, step_w, busy_w;
    pp_sel_t           sel_pair, sel_trip, sel;
    logic [AW-1:0]     m_ext, mag, addend, acc_sum;
    logic signed [CW-1:0] cat_sum, sh1, sh2;
    logic [CW-1:0]     cat_q;

    // Multiplier extension: pad odd widths to an even count of bits.
    generate
        if (QE > WIDTH) begin : g_pad
            assign mplier_ext = {mplier[WIDTH-1], mplier};
        end else begin : g_nopad
            assign mplier_ext = mplier;
        end
    endgenerate

    booth_step_ctrl #(
        .STEPS_R2 (STEPS_R2),
        .STEPS_R4 (STEPS_R4)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .mode_i  (booth_mode_e'(mode)),
        .load_o  (load_w),
        .step_o  (step_w),
        .busy_o  (busy_w),
        .done_o  (done)
    );

    booth_pair_dec pair_i (
        .pair_i ({qr_q[0], qm1_q}),
        .sel_o  (sel_pair)
    );

    booth_triple_dec trip_i (
        .trip_i ({qr_q[1], qr_q[0], qm1_q}),
        .sel_o  (sel_trip)
    );

    // Form the signed addend from the recoder choice and add it.
    always_comb begin
        sel     = (mode_q == MODE_RADIX4) ? sel_trip : sel_pair;
        m_ext   = {{(AW-WIDTH){mcand_q[WIDTH-1]}}, mcand_q};
        mag     = sel.dbl ? {m_ext[AW-2:0], 1'b0} : m_ext;
        addend  = sel.zero ? '0 : (sel.neg ? (~mag + 1'b1) : mag);
        acc_sum = acc_q + addend;
        cat_sum = {acc_sum, qr_q};
        sh1     = cat_sum >>> 1;
        sh2     = cat_sum >>> 2;
    end

    // Operand capture on accept, then one add-and-shift per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            qr_q    <= '0;
            qm1_q   <= 1'b0;
            mcand_q <= '0;
            mode_q  <= MODE_RADIX2;
        end else if (load_w) begin
            acc_q   <= '0;
            qr_q    <= mplier_ext;
            qm1_q   <= 1'b0;
            mcand_q <= mcand;
            mode_q  <= booth_mode_e'(mode);
        end else if (step_w) begin
            if (mode_q == MODE_RADIX4) begin
                {acc_q, qr_q} <= sh2;
                qm1_q         <= qr_q[1];
            end else begin
                {acc_q, qr_q} <= sh1;
                qm1_q         <= qr_q[0];
            end
        end
    end

    assign cat_q   = {acc_q, qr_q};
    assign busy    = busy_w;
    assign product = (mode_q == MODE_RADIX4) ? cat_q[0 +: PW] : cat_q[R2_OFF +: PW];

    logic signed [CW-1:0] prod_sx;
    assign prod_sx = $signed(product);

    p_frozen_ops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |=> ($stable(mcand_q) && $stable(mode_q)));

    p_headroom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_w && mode_q == MODE_RADIX4) |-> ($signed(cat_q) == prod_sx));

    p_headroom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_w && mode_q == MODE_RADIX2) |-> (($signed(cat_q) >>> R2_OFF) == prod_sx));

endmodule

// File: tb/booth_seq_mul_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mul_tb_top;

    localparam int N  = 5;
    localparam int PW = 2 * N;
    localparam int S2 = N;
    localparam int S4 = (N + 1) / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          mode;
    logic [N-1:0]  mcand;
    logic [N-1:0]  mplier;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [PW-1:0] exp_q[$];
    int            due_q[$];
    string         tag_q[$];
    logic [PW-1:0] last_exp;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    booth_seq_mul #(.WIDTH(N)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode    (mode),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: wait for idle, present operands, push the expected result.
    task automatic issue(input int m, input int q, input bit md,
                         input bit use_lit, input logic [PW-1:0] lit, input string tag);
        logic signed [PW-1:0] e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e = $signed(N'(m)) * $signed(N'(q));
        if (use_lit) e = lit;
        mcand  = N'(m);
        mplier = N'(q);
        mode   = md;
        start  = 1'b1;
        exp_q.push_back(e);
        due_q.push_back(cyc + 1 + (md ? S4 : S2));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each done pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                logic [PW-1:0] e;
                int            d;
                string         t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(product === e, t, "product", product, e);
                check(cyc == d, "R3", "done latency cycle", cyc, d);
                check(busy === 1'b0, "R3", "busy low with done", busy, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; mcand = '0; mplier = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy in reset", busy, 0);
        check(done === 1'b0, "R1", "done in reset", done, 0);
        check(product === '0, "R1", "product in reset", product, 0);
        rst_n = 1'b1;

        // R4 / R5: directed products in both schemes
        for (int md = 0; md < 2; md++) begin
            string tg;
            tg = md ? "R5" : "R4";
            issue(-13, 11, md[0], 1'b1, 10'b1101110001, tg);
            issue(13, -6, md[0], 1'b1, 10'b1110110010, tg);
            issue(15, -5, md[0], 1'b1, 10'b1110110101, tg);
            issue(-12, 11, md[0], 1'b1, 10'b1101111100, tg);
            // R7: most negative operands, odd width
            issue(-16, -16, md[0], 1'b1, 10'b0100000000, "R7");
            // R10: alternating multiplier 10101
            issue(15, -11, md[0], 1'b1, 10'(-165), "R10");
        end
        wait_idle();

        // R2 / R9: start, mode and operands changed mid-run are ignored
        issue(7, -3, 1'b0, 1'b0, '0, "R9");
        mcand = 5'b10000; mplier = 5'b10000; mode = 1'b1; start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        issue(-9, 6, 1'b1, 1'b0, '0, "R2");
        mode = 1'b0; mcand = 5'b01111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R8: product holds and done stays low while idle
        repeat (4) @(negedge clk);
        check(product === last_exp, "R8", "product held", product, last_exp);
        check(done === 1'b0, "R8", "done low while idle", done, 0);

        // R6: every operand pair in both schemes
        for (int m = -16; m < 16; m++) begin
            for (int q = -16; q < 16; q++) begin
                issue(m, q, 1'b0, 1'b0, '0, "R6");
                issue(m, q, 1'b1, 1'b0, '0, "R6");
            end
        end
        wait_idle();
        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule